// File: doc/BRIEF.md
# Stereo Audio Serial Receiver

This block receives stereo audio from a three-wire serial link made of a bit clock, a frame-sync (word-select) line and a data line. It runs on the system clock and samples all three link signals with that clock. Each rising edge of the bit clock is one bit time. Each level of the frame-sync line marks one channel, so every frame-sync period yields two samples. Three framing conventions are supported. In left-justified framing the first data bit sits on the bit clock of the frame-sync edge. In I2S framing it sits one bit clock later. In right-justified framing the word fills the last bit clocks before the next frame-sync edge.

A configuration input selects the framing, the word length and the bit order. Every received word is placed at the top of a 32-bit output word with zeros below it, and goes out with a one-cycle valid strobe and a left/right tag. A frame-sync edge that arrives before the current word is complete produces an error pulse. The partial word is then dropped and reception starts again from that edge.

Top module: `asp_rx`

## Requirements
- R1: Framing is chosen by `cfg_fmt_i`: 2'b01 = left-justified, where the first data bit is taken on the bit clock of the frame-sync edge; 2'b00 = I2S, where the first data bit is taken one bit clock after the edge; 2'b10 = right-justified, where the word fills the final N bit clocks before the next frame-sync edge. Code 2'b11 behaves as left-justified.
- R2: The word length N is `cfg_wlen_i`. Values below 8 act as 8 and values above 32 act as 32.
- R3: A received word of N bits appears on `smp_data_o` in bits [31:32-N], and bits [31-N:0] are zero.
- R4: `cfg_lsb_first_i` = 0 means the first bit received is the MSB of the word. A value of 1 means the first bit received is the LSB.
- R5: `smp_left_o` = 1 marks a left sample. Left is frame-sync high in left- and right-justified framing, and frame-sync low in I2S framing.
- R6: Each frame-sync level yields one sample. `smp_valid_o` is a single-cycle pulse in the cycle after the system clock sees the bit clock rise that completes the word. That rise is the last word bit for left-justified and I2S framing, and the next frame-sync edge for right-justified framing.
- R7: If a frame-sync edge arrives before the current word is complete, `fs_err_o` pulses for one cycle and no sample is output for that half-frame. The right-justified case is fewer than N bit clocks since the previous edge.
- R8: After a frame-sync error, the half-frame that starts at the offending edge is received normally.
- R9: After reset all outputs are zero, and no sample or error is reported before the first frame-sync edge has been seen.
- R10: Data-line values outside the word window of R1 (before it, after it, or the I2S delay slot) do not affect the output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the bit clock |
| rst_n | input | 1 | Active-low reset |
| bclk_i | input | 1 | Serial bit clock; data taken on its rising edge |
| fs_i | input | 1 | Frame sync / channel select |
| sd_i | input | 1 | Serial data |
| cfg_fmt_i | input | 2 | Framing code (R1) |
| cfg_wlen_i | input | 6 | Word length in bits (R2) |
| cfg_lsb_first_i | input | 1 | Bit order select (R4) |
| smp_data_o | output | 32 | Received sample, MSB-aligned |
| smp_valid_o | output | 1 | One-cycle strobe for a new sample |
| smp_left_o | output | 1 | 1 = left channel sample |
| fs_err_o | output | 1 | One-cycle early frame-sync pulse |

## Verification
Suppose the bit position counter or the framing offset goes wrong. The damage then shows up in the very next word as a sample that is shifted by one bit, so a bit from outside the window leaks into the top or bottom of the word. The bench fills the data line with ones outside the window to make such a slip visible. Suppose instead the half-frame "done" or sync state goes wrong. That shows at the next frame-sync edge as a spurious or missing error pulse, or as an extra or lost sample. The bench therefore counts samples and errors over each short frame sequence, including the half-frame before the first edge.

// File: rtl/asp_rx_pkg.sv
package asp_rx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_ALT = 2'b11
    } fmt_e;

endpackage

// File: rtl/asp_rx_pins.sv
// Samples the link signals on the system clock and derives bit-time events.
module asp_rx_pins (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_i,
    input  logic fs_i,
    input  logic sd_i,
    output logic tick_o,
    output logic fs_edge_o,
    output logic fs_lvl_o,
    output logic sd_o
);

    typedef struct packed {
        logic bclk;
        logic bclk_prev;
        logic fs;
        logic sd;
        logic fs_last;
        logic seen;
    } pins_t;

    pins_t pin_d, pin_q;
    logic  tick;

    assign tick = pin_q.bclk & ~pin_q.bclk_prev;

    always_comb begin
        pin_d           = pin_q;
        pin_d.bclk      = bclk_i;
        pin_d.bclk_prev = pin_q.bclk;
        pin_d.fs        = fs_i;
        pin_d.sd        = sd_i;
        if (tick) begin
            pin_d.fs_last = pin_q.fs;
            pin_d.seen    = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= '0;
        else        pin_q <= pin_d;
    end

    assign tick_o    = tick;
    assign fs_edge_o = tick & pin_q.seen & (pin_q.fs != pin_q.fs_last);
    assign fs_lvl_o  = pin_q.fs;
    assign sd_o      = pin_q.sd;

    // R6
    tick_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/asp_rx_framer.sv
// Tracks bit position within each half-frame, decides which bits are word bits,
// when a word is complete and when a frame sync came too early.
module asp_rx_framer
    import asp_rx_pkg::*;
#(
    parameter int WLEN_W = 6,
    parameter int CNT_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              fs_edge_i,
    input  logic              fs_lvl_i,
    input  fmt_e              fmt_i,
    input  logic [WLEN_W-1:0] wlen_i,
    output logic              shift_o,
    output logic              emit_hist_o,
    output logic              emit_word_o,
    output logic              emit_left_o,
    output logic              err_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             synced;
        logic             done;
        logic             half_lvl;
    } frm_t;

    frm_t frm_d, frm_q;

    logic             is_i2s, is_rj, lvl;
    logic [CNT_W-1:0] pos, off, wl, last;

    always_comb begin
        frm_d       = frm_q;
        shift_o     = 1'b0;
        emit_hist_o = 1'b0;
        emit_word_o = 1'b0;
        err_o       = 1'b0;
        lvl         = frm_q.half_lvl;
        is_i2s      = (fmt_i == FMT_I2S);
        is_rj       = (fmt_i == FMT_RJ);
        off         = is_i2s ? CNT_W'(1) : '0;
        wl          = CNT_W'(wlen_i);
        last        = off + wl - CNT_W'(1);
        pos         = fs_edge_i ? '0 : frm_q.cnt;

        if (tick_i) begin
            if (fs_edge_i) begin
                if (frm_q.synced) begin
                    if (is_rj) begin
                        if (frm_q.cnt >= wl) emit_hist_o = 1'b1;
                        else                 err_o       = 1'b1;
                    end else if (!frm_q.done) begin
                        err_o = 1'b1;
                    end
                end
                frm_d.synced   = 1'b1;
                frm_d.half_lvl = fs_lvl_i;
                frm_d.done     = 1'b0;
            end

            frm_d.cnt = (pos == CNT_MAX) ? pos : pos + CNT_W'(1);

            if (is_rj) begin
                shift_o = 1'b1;
            end else if (frm_d.synced && pos >= off && pos <= last) begin
                shift_o = 1'b1;
                if (pos == last) begin
                    emit_word_o = 1'b1;
                    frm_d.done  = 1'b1;
                    lvl         = frm_d.half_lvl;
                end
            end
        end

        emit_left_o = lvl ^ is_i2s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frm_q <= '0;
        else        frm_q <= frm_d;
    end

    // R1
    pos_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && !fs_edge_i && frm_q.cnt != CNT_MAX) |=> (frm_q.cnt == $past(frm_q.cnt) + CNT_W'(1)));

    // R7
    err_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (tick_i && fs_edge_i && frm_q.synced));

    // R9
    done_needs_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frm_q.done |-> frm_q.synced);

endmodule

// File: rtl/asp_rx_shifter.sv
// Serial-to-parallel register with bit-order select and MSB alignment.
module asp_rx_shifter #(
    parameter int SAMPLE_W = 32,
    parameter int WLEN_W   = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                shift_i,
    input  logic                sd_i,
    input  logic                lsb_first_i,
    input  logic [WLEN_W-1:0]   wlen_i,
    output logic [SAMPLE_W-1:0] aligned_cur_o,
    output logic [SAMPLE_W-1:0] aligned_next_o
);

    localparam logic [SAMPLE_W-1:0] ONES = '1;

    logic [SAMPLE_W-1:0] shr_d, shr_q;
    logic [WLEN_W-1:0]   up_amt;

    function automatic logic [SAMPLE_W-1:0] align_word(input logic [SAMPLE_W-1:0] v,
                                                       input logic              lsbf,
                                                       input logic [WLEN_W-1:0] wl,
                                                       input logic [WLEN_W-1:0] amt);
        if (lsbf) return v & ~(ONES >> wl);
        else      return v << amt;
    endfunction

    always_comb begin
        shr_d  = shr_q;
        up_amt = WLEN_W'(SAMPLE_W) - wlen_i;
        if (shift_i) begin
            if (lsb_first_i) shr_d = {sd_i, shr_q[SAMPLE_W-1:1]};
            else             shr_d = {shr_q[SAMPLE_W-2:0], sd_i};
        end
        aligned_cur_o  = align_word(shr_q, lsb_first_i, wlen_i, up_amt);
        aligned_next_o = align_word(shr_d, lsb_first_i, wlen_i, up_amt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shr_q <= '0;
        else        shr_q <= shr_d;
    end

endmodule

// File: rtl/asp_rx.sv
// Stereo audio serial receiver top level.
module asp_rx
    import asp_rx_pkg::*;
#(
    parameter  int SAMPLE_W = 32,
    parameter  int MIN_WLEN = 8,
    localparam int WLEN_W   = $clog2(SAMPLE_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_i,
    input  logic                fs_i,
    input  logic                sd_i,
    input  logic [1:0]          cfg_fmt_i,
    input  logic [WLEN_W-1:0]   cfg_wlen_i,
    input  logic                cfg_lsb_first_i,
    output logic [SAMPLE_W-1:0] smp_data_o,
    output logic                smp_valid_o,
    output logic                smp_left_o,
    output logic                fs_err_o
);

    localparam int                  CNT_W = WLEN_W + 1;
    localparam logic [SAMPLE_W-1:0] ONES  = '1;

    typedef struct packed {
        logic [SAMPLE_W-1:0] data;
        logic                valid;
        logic                left;
        logic                err;
    } out_t;

    out_t out_d, out_q;

    logic                tick, fs_edge, fs_lvl, sd;
    logic                shift, emit_hist, emit_word, emit_left, err;
    logic [WLEN_W-1:0]   wlen_eff;
    logic [SAMPLE_W-1:0] aligned_cur, aligned_next;
    fmt_e                fmt;

    assign fmt = fmt_e'(cfg_fmt_i);

    always_comb begin
        if (cfg_wlen_i < WLEN_W'(MIN_WLEN))      wlen_eff = WLEN_W'(MIN_WLEN);
        else if (cfg_wlen_i > WLEN_W'(SAMPLE_W)) wlen_eff = WLEN_W'(SAMPLE_W);
        else                                     wlen_eff = cfg_wlen_i;
    end

    asp_rx_pins i_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk_i    (bclk_i),
        .fs_i      (fs_i),
        .sd_i      (sd_i),
        .tick_o    (tick),
        .fs_edge_o (fs_edge),
        .fs_lvl_o  (fs_lvl),
        .sd_o      (sd)
    );

    asp_rx_framer #(
        .WLEN_W (WLEN_W),
        .CNT_W  (CNT_W)
    ) i_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .fs_edge_i   (fs_edge),
        .fs_lvl_i    (fs_lvl),
        .fmt_i       (fmt),
        .wlen_i      (wlen_eff),
        .shift_o     (shift),
        .emit_hist_o (emit_hist),
        .emit_word_o (emit_word),
        .emit_left_o (emit_left),
        .err_o       (err)
    );

    asp_rx_shifter #(
        .SAMPLE_W (SAMPLE_W),
        .WLEN_W   (WLEN_W)
    ) i_shifter (
        .clk            (clk),
        .rst_n          (rst_n),
        .shift_i        (shift),
        .sd_i           (sd),
        .lsb_first_i    (cfg_lsb_first_i),
        .wlen_i         (wlen_eff),
        .aligned_cur_o  (aligned_cur),
        .aligned_next_o (aligned_next)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = emit_hist | emit_word;
        out_d.err   = err;
        if (emit_word) begin
            out_d.data = aligned_next;
            out_d.left = emit_left;
        end else if (emit_hist) begin
            out_d.data = aligned_cur;
            out_d.left = emit_left;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign smp_data_o  = out_q.data;
    assign smp_valid_o = out_q.valid;
    assign smp_left_o  = out_q.left;
    assign fs_err_o    = out_q.err;

    // R6
    valid_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.valid |-> $past(tick));

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.valid |=> !out_q.valid);

    // R7
    err_no_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_q.err && out_q.valid));

    // R3
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_q.valid |-> ((out_q.data & (ONES >> $past(wlen_eff))) == '0));

endmodule

// File: tb/test_asp_rx.sv
module test_asp_rx;

    typedef struct packed {
        logic [1:0]  fmt;
        logic [5:0]  wlen;
        logic        lsbf;
        logic        fill;
        logic [31:0] lval;
        logic [31:0] rval;
        logic [6:0]  half;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'b01, 6'd24, 1'b0, 1'b0, 32'h00ABCDEF, 32'h00123456, 7'd32},
        '{2'b00, 6'd32, 1'b0, 1'b1, 32'hDEADBEEF, 32'h0F1E2D3C, 7'd40},
        '{2'b10, 6'd16, 1'b0, 1'b1, 32'h0000BEEF, 32'h00001234, 7'd32},
        '{2'b10, 6'd20, 1'b1, 1'b1, 32'h000ABCDE, 32'h00054321, 7'd24},
        '{2'b01, 6'd8,  1'b1, 1'b1, 32'h000000A5, 32'h0000003C, 7'd16},
        '{2'b00, 6'd18, 1'b1, 1'b0, 32'h0002AAAA, 32'h00015555, 7'd20},
        '{2'b01, 6'd4,  1'b0, 1'b1, 32'h000000C3, 32'h0000005A, 7'd16},
        '{2'b00, 6'd40, 1'b0, 1'b1, 32'h80000001, 32'h7FFFFFFE, 7'd34},
        '{2'b10, 6'd24, 1'b0, 1'b0, 32'h00800001, 32'h007FFFFE, 7'd24}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0;
    logic        fs = 1'b0;
    logic        sd = 1'b0;
    logic [1:0]  cfg_fmt = 2'b01;
    logic [5:0]  cfg_wlen = 6'd24;
    logic        cfg_lsbf = 1'b0;
    logic [31:0] smp_data;
    logic        smp_valid, smp_left, fs_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [31:0] cap_data [256];
    logic        cap_left [256];
    int          cap_n = 0;
    int          err_n = 0;

    always #2 clk = ~clk;

    asp_rx i_asp_rx (
        .clk             (clk),
        .rst_n           (rst_n),
        .bclk_i          (bclk),
        .fs_i            (fs),
        .sd_i            (sd),
        .cfg_fmt_i       (cfg_fmt),
        .cfg_wlen_i      (cfg_wlen),
        .cfg_lsb_first_i (cfg_lsbf),
        .smp_data_o      (smp_data),
        .smp_valid_o     (smp_valid),
        .smp_left_o      (smp_left),
        .fs_err_o        (fs_err)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (smp_valid && cap_n < 256) begin
                cap_data[cap_n] = smp_data;
                cap_left[cap_n] = smp_left;
                cap_n = cap_n + 1;
            end
            if (fs_err) err_n = err_n + 1;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int eff_wlen(input int w);
        if (w < 8) return 8;
        if (w > 32) return 32;
        return w;
    endfunction

    function automatic logic [31:0] expect_word(input logic [31:0] v, input int w);
        logic [63:0] m;
        m = ((64'd1 << w) - 64'd1) & {32'd0, v};
        return 32'(m << (32 - w));
    endfunction

    task automatic drive_bit(input logic lvl, input logic b);
        @(negedge clk);
        bclk = 1'b0;
        fs = lvl;
        sd = b;
        @(negedge clk);
        @(negedge clk);
        bclk = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_half(input logic [1:0] fmt, input int w, input logic lsbf, input logic fill,
                             input logic [31:0] v, input int h, input logic lvl);
        for (int i = 0; i < h; i++) begin
            int k;
            logic b;
            if (fmt == 2'b00)      k = i - 1;
            else if (fmt == 2'b10) k = i - (h - w);
            else                   k = i;
            if (k >= 0 && k < w) b = lsbf ? v[k] : v[w - 1 - k];
            else                 b = fill;
            drive_bit(lvl, b);
        end
    endtask

    task automatic do_reset(input logic [1:0] fmt, input logic [5:0] wl, input logic lsbf);
        @(negedge clk);
        rst_n = 1'b0;
        bclk = 1'b0;
        fs = 1'b0;
        sd = 1'b0;
        cfg_fmt = fmt;
        cfg_wlen = wl;
        cfg_lsbf = lsbf;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        do_reset(2'b01, 6'd24, 1'b0);
        check(smp_data == 32'd0, "R9 reset data", smp_data, 32'd0);
        check(smp_valid == 1'b0 && fs_err == 1'b0 && smp_left == 1'b0,
              "R9 reset strobes", {29'd0, smp_valid, fs_err, smp_left}, 32'd0);

        // Table walk: R1 R2 R3 R4 R5 R6 R9 R10
        for (int n = 0; n < NVEC; n++) begin
            vec_t  vc;
            int    w, base, ebase, nexp;
            logic  llvl;
            vc = VECS[n];
            w = eff_wlen(int'(vc.wlen));
            llvl = (vc.fmt == 2'b00) ? 1'b0 : 1'b1;
            do_reset(vc.fmt, vc.wlen, vc.lsbf);
            base = cap_n;
            ebase = err_n;
            send_half(vc.fmt, w, vc.lsbf, vc.fill, 32'hFFFFFFFF, int'(vc.half), ~llvl);
            send_half(vc.fmt, w, vc.lsbf, vc.fill, vc.lval, int'(vc.half), llvl);
            send_half(vc.fmt, w, vc.lsbf, vc.fill, vc.rval, int'(vc.half), ~llvl);
            send_half(vc.fmt, w, vc.lsbf, vc.fill, vc.lval, int'(vc.half), llvl);
            repeat (4) @(negedge clk);
            nexp = (vc.fmt == 2'b10) ? 2 : 3;
            check(cap_n - base == nexp, $sformatf("R6 R9 sample count vec%0d", n),
                  32'(cap_n - base), 32'(nexp));
            check(err_n == ebase, $sformatf("R7 no spurious error vec%0d", n),
                  32'(err_n - ebase), 32'd0);
            if (cap_n - base == nexp) begin
                for (int s = 0; s < nexp; s++) begin
                    logic [31:0] ev;
                    logic        el;
                    ev = expect_word((s == 1) ? vc.rval : vc.lval, w);
                    el = (s != 1);
                    check(cap_data[base + s] == ev,
                          $sformatf("R1 R2 R3 R4 R10 data vec%0d smp%0d", n, s),
                          cap_data[base + s], ev);
                    check(cap_left[base + s] == el, $sformatf("R5 channel vec%0d smp%0d", n, s),
                          {31'd0, cap_left[base + s]}, {31'd0, el});
                end
            end
        end

        // R7 R8: early frame sync, left-justified
        begin
            int base, ebase;
            do_reset(2'b01, 6'd24, 1'b0);
            base = cap_n;
            ebase = err_n;
            send_half(2'b01, 24, 1'b0, 1'b1, 32'hFFFFFF, 32, 1'b0);
            send_half(2'b01, 24, 1'b0, 1'b1, 32'h111111, 10, 1'b1);
            send_half(2'b01, 24, 1'b0, 1'b0, 32'h9A5C3E, 32, 1'b0);
            send_half(2'b01, 24, 1'b0, 1'b0, 32'h0F0F0F, 32, 1'b1);
            repeat (4) @(negedge clk);
            check(err_n - ebase == 1, "R7 lj early sync error count", 32'(err_n - ebase), 32'd1);
            check(cap_n - base == 2, "R7 lj partial word dropped", 32'(cap_n - base), 32'd2);
            check(cap_data[base] == 32'h9A5C3E00 && cap_left[base] == 1'b0,
                  "R8 lj resync sample", cap_data[base], 32'h9A5C3E00);
            check(cap_data[base + 1] == 32'h0F0F0F00, "R8 lj following sample",
                  cap_data[base + 1], 32'h0F0F0F00);
        end

        // R7 R8: early frame sync, right-justified
        begin
            int base, ebase;
            do_reset(2'b10, 6'd20, 1'b0);
            base = cap_n;
            ebase = err_n;
            send_half(2'b10, 20, 1'b0, 1'b1, 32'hFFFFF, 24, 1'b0);
            send_half(2'b10, 20, 1'b0, 1'b1, 32'h12345, 12, 1'b1);
            send_half(2'b10, 20, 1'b0, 1'b1, 32'hC0FFE, 24, 1'b0);
            send_half(2'b10, 20, 1'b0, 1'b1, 32'h00000, 24, 1'b1);
            repeat (4) @(negedge clk);
            check(err_n - ebase == 1, "R7 rj short half error count", 32'(err_n - ebase), 32'd1);
            check(cap_n - base == 1, "R7 rj short half dropped", 32'(cap_n - base), 32'd1);
            check(cap_data[base] == 32'hC0FFE000 && cap_left[base] == 1'b0,
                  "R8 rj resync sample", cap_data[base], 32'hC0FFE000);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule